// File: doc/BRIEF.md
# Four-Bit Character Panel Boot Sequencer

This block runs on the host side of a character display module that is wired with a 4-bit data bus. It leaves reset, waits out the panel's power-on settling time, and then sends the panel its start-up transfers. First come three blind "8-bit interface" nibbles with waits that get shorter each time. Next comes one nibble that switches the panel to 4-bit transfers. Last come four configuration bytes: function set, display off, clear, and entry mode. Each byte goes out as two nibbles, high nibble first. Each nibble is latched by one enable pulse. The data lines are set up before the pulse rises and stay held after it falls.

The busy flag is never read. Every wait is a fixed count of clock cycles set by a parameter, and the count after each command must be longer than that command's execution time. The line count, font, cursor direction and display shift are parameters of the block. When the last wait has elapsed, the block raises a ready flag and keeps the bus idle.

Top module: `chr_disp_boot`

## Requirements
- R1: After reset is released, the first rising edge of `bus_en` comes exactly T_POWER + T_SETUP cycles later. Before that, `bus_en` and `ready` stay low.
- R2: The first three nibbles are 4'h3. The gap after the first is T_WAIT1 cycles, the gap after the second is T_WAIT2 cycles, and the gap after the third is T_CMD cycles.
- R3: The fourth nibble is 4'h2, sent alone, and is followed by a T_CMD gap.
- R4: Function set goes out as 4'h2 and then {two_lines, tall_font, 0, 0}, high nibble first. Bit 3 of the low nibble set to 1 means two lines.
- R5: When LINES2 = 1, the font bit (bit 2 of the function-set low nibble) is forced to 0, whatever FONT_TALL is.
- R6: After function set, the block sends display-off (4'h0, 4'h8), then clear (4'h0, 4'h1), then entry mode (4'h0, {0, 1, DIR_INC, DISP_SHIFT}), in that order. That makes 12 nibbles in total.
- R7: The gap between the two nibbles of one byte is T_NIBGAP cycles. The gap after a whole byte is T_CMD cycles, except after clear, where it is T_CLEAR cycles. The spacing from one rising edge of `bus_en` to the next is T_ENHI + T_HOLD + gap + T_SETUP.
- R8: Each `bus_en` pulse is high for exactly T_ENHI cycles. `bus_nib` is stable from at least one cycle before the rising edge through the falling edge.
- R9: `bus_rs` and `bus_rw` are 0 at all times.
- R10: `ready` rises exactly T_HOLD + T_CMD cycles after the last falling edge of `bus_en`. Once high, it stays high and `bus_en` stays low.
- R11: Asserting reset at any point sets `bus_en` and `ready` low, and the whole sequence starts again from R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rs | output | 1 | Register select to the panel (always 0) |
| bus_rw | output | 1 | Read/write select to the panel (always 0, write) |
| bus_en | output | 1 | Enable strobe; the panel latches the data on the falling edge |
| bus_nib | output | 4 | Data nibble for the panel's upper four data pins |
| ready | output | 1 | Sequence complete |

## Verification
The assertions check on every cycle the local rules of the enable strobe: the pulse width, the data held stable through the pulse, and step advances that happen only when a gap expires while the strobe is low. They also check that `ready` is sticky and that the bus stays quiet once it is set. Only the bench scenarios can show the global order and values of the twelve nibbles, the font override in two-line mode, and the exact length of each gap, including the long gap after clear. The bench shows these by timing each edge of the strobe against a count of cycles since reset and comparing against values it works out from the parameters. A scenario with reset asserted mid-sequence shows that the sequence restarts from the beginning.

// File: rtl/boot_pkg.sv
package boot_pkg;

  typedef enum logic [2:0] {
    PH_PWR, PH_SETUP, PH_STROBE, PH_HOLD, PH_GAP, PH_DONE
  } boot_phase_t;

  localparam int unsigned NUM_STEPS = 12;

  // nibble placed on the bus for a given step
  function automatic logic [3:0] step_nibble(input int unsigned k, input bit two,
                                             input bit tall, input bit inc, input bit shf);
    logic [3:0] v;
    case (k)
      0, 1, 2:   v = 4'h3;
      3, 4:      v = 4'h2;
      5:         v = {two, tall & ~two, 2'b00};
      7:         v = 4'h8;
      9:         v = 4'h1;
      11:        v = {2'b01, inc, shf};
      default:   v = 4'h0;
    endcase
    return v;
  endfunction

  // idle cycles that follow the strobe of a given step
  function automatic int unsigned step_gap(input int unsigned k, input int unsigned w1,
                                           input int unsigned w2, input int unsigned cmd,
                                           input int unsigned clr, input int unsigned nib);
    int unsigned g;
    case (k)
      0:                g = w1;
      1:                g = w2;
      2, 3, 5, 7, 11:   g = cmd;
      9:                g = clr;
      default:          g = nib;
    endcase
    return g;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/boot_timer.sv
module boot_timer #(
  parameter int unsigned CW      = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= CW'(RST_VAL);
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/boot_stepper.sv
module boot_stepper #(
  parameter int unsigned STEPS = 12,
  localparam int unsigned SW   = $clog2(STEPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [SW-1:0] idx,
  output logic          last
);
  always_ff @(posedge clk) begin
    if (!rst_n)              idx <= '0;
    else if (adv && !last)   idx <= idx + 1'b1;
  end

  assign last = (idx == SW'(STEPS - 1));
endmodule

// File: rtl/chr_disp_boot.sv
module chr_disp_boot
  import boot_pkg::*;
#(
  parameter bit          LINES2     = 1'b0,
  parameter bit          FONT_TALL  = 1'b1,
  parameter bit          DIR_INC    = 1'b1,
  parameter bit          DISP_SHIFT = 1'b0,
  parameter int unsigned T_POWER    = 60,
  parameter int unsigned T_WAIT1    = 20,
  parameter int unsigned T_WAIT2    = 8,
  parameter int unsigned T_CMD      = 6,
  parameter int unsigned T_CLEAR    = 30,
  parameter int unsigned T_NIBGAP   = 2,
  parameter int unsigned T_SETUP    = 2,
  parameter int unsigned T_ENHI     = 3,
  parameter int unsigned T_HOLD     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       bus_rs,
  output logic       bus_rw,
  output logic       bus_en,
  output logic [3:0] bus_nib,
  output logic       ready
);
  localparam int unsigned TMAX = max2(max2(max2(T_POWER, T_WAIT1), max2(T_WAIT2, T_CMD)),
                                      max2(max2(T_CLEAR, T_NIBGAP), max2(T_SETUP, max2(T_ENHI, T_HOLD))));
  localparam int unsigned CW   = $clog2(TMAX + 1);
  localparam int unsigned SW   = $clog2(NUM_STEPS);

  boot_phase_t   phase;
  logic          tmr_zero, tmr_load, step_adv, step_last;
  logic [CW-1:0] tmr_val;
  logic [SW-1:0] step_idx;

  boot_timer #(.CW(CW), .RST_VAL(T_POWER - 1)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  boot_stepper #(.STEPS(NUM_STEPS)) u_step (
    .clk(clk), .rst_n(rst_n), .adv(step_adv), .idx(step_idx), .last(step_last)
  );

  assign tmr_load = tmr_zero && (phase != PH_DONE);
  assign step_adv = tmr_zero && (phase == PH_GAP) && !step_last;

  always_comb begin
    case (phase)
      PH_PWR, PH_GAP: tmr_val = CW'(T_SETUP - 1);
      PH_SETUP:       tmr_val = CW'(T_ENHI - 1);
      PH_STROBE:      tmr_val = CW'(T_HOLD - 1);
      PH_HOLD:        tmr_val = CW'(step_gap(int'(step_idx), T_WAIT1, T_WAIT2,
                                             T_CMD, T_CLEAR, T_NIBGAP) - 1);
      default:        tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_PWR;
    else if (tmr_zero) begin
      case (phase)
        PH_PWR:    phase <= PH_SETUP;
        PH_SETUP:  phase <= PH_STROBE;
        PH_STROBE: phase <= PH_HOLD;
        PH_HOLD:   phase <= PH_GAP;
        PH_GAP:    phase <= step_last ? PH_DONE : PH_SETUP;
        default:   phase <= PH_DONE;
      endcase
    end
  end

  assign bus_rs  = 1'b0;
  assign bus_rw  = 1'b0;
  assign bus_en  = (phase == PH_STROBE);
  assign bus_nib = step_nibble(int'(step_idx), LINES2, FONT_TALL, DIR_INC, DISP_SHIFT);
  assign ready   = (phase == PH_DONE);
endmodule

// File: rtl/boot_chk.sv
module boot_chk #(
  parameter int unsigned T_ENHI = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_en,
  input logic [3:0] bus_nib,
  input logic       ready,
  input logic       step_adv,
  input logic       tmr_zero
);
  logic [15:0] hi_len;

  always_ff @(posedge clk) begin
    if (!rst_n)      hi_len <= '0;
    else if (bus_en) hi_len <= hi_len + 1'b1;
    else             hi_len <= '0;
  end

  a_r8_pulse_not_long: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |-> (hi_len < 16'(T_ENHI)));
  a_r8_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_en) |-> (hi_len == 16'(T_ENHI)));
  a_r8_setup_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_en) |-> $stable(bus_nib));
  a_r8_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en || $fell(bus_en)) && $past(bus_en) |-> $stable(bus_nib));
  a_r10_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  a_r10_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !bus_en);
  a_r7_step_on_gap_end: assert property (@(posedge clk) disable iff (!rst_n)
    step_adv |-> (tmr_zero && !bus_en));
endmodule

bind chr_disp_boot boot_chk #(.T_ENHI(T_ENHI)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_nib(bus_nib),
  .ready(ready), .step_adv(step_adv), .tmr_zero(tmr_zero)
);

// File: tb/sim_chr_disp_boot.sv
module sim_chr_disp_boot;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rs0, rw0, en0, rd0, rs1, rw1, en1, rd1;
  logic [3:0] nb0, nb1;

  // scenario A: one line, tall font requested, increment, no shift
  chr_disp_boot u0 (.clk(clk), .rst_n(rst_n), .bus_rs(rs0), .bus_rw(rw0),
                    .bus_en(en0), .bus_nib(nb0), .ready(rd0));

  // scenario B: two lines with tall font (must be overridden), decrement, shift, tight timing
  chr_disp_boot #(.LINES2(1'b1), .FONT_TALL(1'b1), .DIR_INC(1'b0), .DISP_SHIFT(1'b1),
                  .T_POWER(40), .T_WAIT1(15), .T_WAIT2(5), .T_CMD(4), .T_CLEAR(25),
                  .T_NIBGAP(1), .T_SETUP(1), .T_ENHI(1), .T_HOLD(1)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_rs(rs1), .bus_rw(rw1),
    .bus_en(en1), .bus_nib(nb1), .ready(rd1));

  int n_chk = 0;
  int n_bad = 0;
  int wd = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<=%0d", wd, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // timing set per scenario: power, w1, w2, cmd, clear, nibgap, setup, enhi, hold
  function automatic int tp(input int which, input int k);
    int a[9] = '{60, 20, 8, 6, 30, 2, 2, 3, 2};
    int b[9] = '{40, 15, 5, 4, 25, 1, 1, 1, 1};
    return which ? b[k] : a[k];
  endfunction

  function automatic int exp_gap(input int which, input int k);
    if (k == 0) return tp(which, 1);
    if (k == 1) return tp(which, 2);
    if (k == 9) return tp(which, 4);
    if (k == 4 || k == 6 || k == 8 || k == 10) return tp(which, 5);
    return tp(which, 3);
  endfunction

  function automatic int exp_nib(input int which, input int k);
    int seq[12];
    seq = '{3, 3, 3, 2, 2, 0, 0, 8, 0, 1, 0, 0};
    // R5: scenario B asks for two lines, so the font bit reads 0 -> 4'b1000
    seq[5]  = which ? 8 : 4;
    // R6: entry mode {0,1,inc,shift}: A inc=1 shift=0 -> 6, B inc=0 shift=1 -> 5
    seq[11] = which ? 5 : 6;
    return seq[k];
  endfunction

  task automatic apply_reset(input int which);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk((which ? en1 : en0) == 1'b0, "R11 enable low in reset", which ? en1 : en0, 0);
    chk((which ? rd1 : rd0) == 1'b0, "R11 ready low in reset", which ? rd1 : rd0, 0);
    rst_n = 1'b1;
  endtask

  task automatic run_boot(input int which);
    int rise[12], fall[12], nib[12];
    int nr = 0, nf = 0, cyc = 0, done_at = -1;
    bit pen = 0, side_bad = 0, stab_bad = 0, early_bad = 0;
    logic [3:0] pd = 4'h0;
    logic e, d, r, w; logic [3:0] n;
    apply_reset(which);
    while (done_at < 0 && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      e = which ? en1 : en0; n = which ? nb1 : nb0; d = which ? rd1 : rd0;
      r = which ? rs1 : rs0; w = which ? rw1 : rw0;
      if (r || w) side_bad = 1;
      if (nr == 0 && (e || d)) begin
        if (cyc < tp(which, 0) + tp(which, 6)) early_bad = 1;
      end
      if (e && !pen && nr < 12) begin
        rise[nr] = cyc; nib[nr] = n;
        if (n != pd) stab_bad = 1;
        nr++;
      end
      if (e && pen && n != pd) stab_bad = 1;
      if (!e && pen && nf < 12) begin
        fall[nf] = cyc;
        if (n != pd) stab_bad = 1;
        nf++;
      end
      if (d && done_at < 0) done_at = cyc;
      pen = e; pd = n;
    end
    chk(!early_bad, "R1 bus quiet during power wait", early_bad, 0);
    chk(nr == 12 && nf == 12, "R6 twelve nibbles", nr, 12);
    if (nr == 12 && nf == 12) begin
      chk(rise[0] == tp(which, 0) + tp(which, 6), "R1 first strobe time", rise[0], tp(which, 0) + tp(which, 6));
      for (int k = 0; k < 12; k++) begin
        chk(nib[k] == exp_nib(which, k), k < 3 ? "R2 nibble" : k == 3 ? "R3 nibble" :
            k == 5 ? "R5 nibble" : k < 6 ? "R4 nibble" : "R6 nibble", nib[k], exp_nib(which, k));
        chk(fall[k] - rise[k] == tp(which, 7), "R8 strobe width", fall[k] - rise[k], tp(which, 7));
      end
      for (int k = 1; k < 12; k++) begin
        int ex = tp(which, 7) + tp(which, 8) + exp_gap(which, k - 1) + tp(which, 6);
        chk(rise[k] - rise[k-1] == ex, k <= 3 ? "R2 gap" : "R7 gap", rise[k] - rise[k-1], ex);
      end
      chk(done_at - fall[11] == tp(which, 8) + tp(which, 3), "R10 ready time",
          done_at - fall[11], tp(which, 8) + tp(which, 3));
    end
    chk(!stab_bad, "R8 data stable around strobe", stab_bad, 0);
    chk(!side_bad, "R9 rs and rw low", side_bad, 0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!(which ? rd1 : rd0) || (which ? en1 : en0)) side_bad = 1;
    end
    chk(!side_bad, "R10 ready sticky and bus idle", side_bad, 0);
  endtask

  task automatic scen_one_line;
    run_boot(0);
  endtask

  task automatic scen_two_line_override;
    run_boot(1);
  endtask

  task automatic scen_reset_midway;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (70) @(negedge clk);
    // R11: reset in the middle of the blind nibbles, then a full clean restart
    run_boot(0);
  endtask

  initial begin
    scen_one_line();
    scen_two_line_override();
    scen_reset_midway();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule